// File: doc/BRIEF.md
# Clock-Hand Victim Selector

This block picks which of a fixed set of resident page frames to evict, using the second-chance (clock) policy. Each frame carries one referenced bit, which an access port sets whenever the frame is touched. The frames form a ring, and a single hand pointer is at once the oldest entry and the point where the next arrival is placed.

When a victim is requested, the hand examines one frame per cycle. A frame with its bit set gets a second chance: the bit is cleared and the hand moves on. The first frame found with a clear bit is reported as the victim, with a one-cycle valid pulse. The hand then stays on that frame until the new page has been installed. An install pulse clears that frame's bit and moves the hand one step, so the frame just filled becomes the newest entry in the ring. If every bit is set, the hand goes all the way round and clears each bit. It then chooses the frame it started from, which is the plain first-in-first-out choice. A clear-all input lets an ageing timer wipe every referenced bit at once.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset the hand is at frame 0, every referenced bit is clear and `victim_valid` is low, so the first request reports frame 0.
- R2: While searching, the hand looks at one frame per cycle. A frame whose bit is set has that bit cleared, and the hand moves to the next frame.
- R3: The first frame with a clear bit is the victim. `victim_valid` is high for exactly one cycle with `victim_idx` equal to that frame. This happens k+1 cycles after the cycle in which `victim_req` is sampled, where k is the number of frames skipped.
- R4: An `install` pulse, accepted only while a victim is held, moves the hand one frame past the victim and leaves the victim's bit clear, even if that frame was referenced while it was held.
- R5: If all N bits are set when the search starts, the hand clears all of them in N cycles and then selects the frame it started from.
- R6: `victim_req` is ignored while a search is running or a victim is held. `install` is ignored when no victim is held.
- R7: A `ref_valid` pulse with `ref_idx` = i sets the bit of frame i, so a later search skips that frame.
- R8: `clear_all` clears every bit, except the bit of a frame referenced in the same cycle, which ends up set.
- R9: A reference to a frame in the same cycle in which the hand clears that frame's bit is lost, and the bit ends clear. A clear performed by an install works the same way.
- R10: The hand wraps from frame N-1 to frame 0, so a search may end at a lower index than the one it started from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A frame was accessed this cycle |
| ref_idx | input | IDX_W | Index of the accessed frame |
| clear_all | input | 1 | Clear every referenced bit |
| victim_req | input | 1 | Start a victim search (accepted when idle) |
| install | input | 1 | New page loaded into the held victim frame |
| victim_valid | output | 1 | One-cycle pulse: victim found |
| victim_idx | output | IDX_W | Index of the victim frame |

## Verification
The bench builds the block with the default 16 frames, which is small enough to fill every bit by hand. This brings the full sweep, with its 17-cycle latency, and the wrap from frame 15 to frame 0 within reach of short directed sequences. The hidden referenced bits are observed through later searches: the skip count and the chosen index show which bits were set. This includes the reference that collides with the hand's clear, and a reference made to a victim while it is held.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_HOLD = 2'd2
  } scan_state_e;
endpackage

// File: rtl/cvs_ref_bits.sv
module cvs_ref_bits #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             clr_all,
  output logic [N-1:0]     bits_o
);
  logic [N-1:0] bits_q;

  // Priority per frame: hand/install clear > access set > clear-all.
  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    always_ff @(posedge clk) begin
      if (rst)
        bits_q[i] <= 1'b0;
      else if (clr_en && clr_idx == MY_IDX)
        bits_q[i] <= 1'b0;
      else if (set_en && set_idx == MY_IDX)
        bits_q[i] <= 1'b1;
      else if (clr_all)
        bits_q[i] <= 1'b0;
    end
  end

  assign bits_o = bits_q;

  // R7: an access not colliding with a clear always lands
  p_set_lands_r7: assert property (@(posedge clk) disable iff (rst)
    (set_en && !(clr_en && clr_idx == set_idx)
     && ({1'b0, set_idx} < (IDX_W+1)'(N)))
    |=> bits_q[$past(set_idx)]);

  // R8: clear-all without any access leaves no bit set
  p_clear_all_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !set_en) |=> (bits_q == '0));
endmodule

// File: rtl/cvs_hand.sv
module cvs_hand #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [IDX_W-1:0] hand_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (step)
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign hand_o = ptr_q;

  // R10: hand never leaves the ring
  p_hand_range_r10: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, ptr_q} < (IDX_W+1)'(N)));
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             clear_all,
  input  logic             victim_req,
  input  logic             install,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_idx
);
  import cvs_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  scan_state_e      state_q;
  logic [IDX_W-1:0] hand;
  logic [N-1:0]     bits;
  logic             cur_bit;
  logic             skip;
  logic             found;
  logic             do_install;
  logic             hand_step;
  logic             vv_q;
  logic [IDX_W-1:0] vi_q;

  assign cur_bit    = bits[hand];
  assign skip       = (state_q == S_SCAN) && cur_bit;
  assign found      = (state_q == S_SCAN) && !cur_bit;
  assign do_install = (state_q == S_HOLD) && install;
  assign hand_step  = skip || do_install;

  cvs_hand #(.N(N), .IDX_W(IDX_W)) u_hand (
    .clk    (clk),
    .rst    (rst),
    .step   (hand_step),
    .hand_o (hand)
  );

  cvs_ref_bits #(.N(N), .IDX_W(IDX_W)) u_bits (
    .clk     (clk),
    .rst     (rst),
    .set_en  (ref_valid),
    .set_idx (ref_idx),
    .clr_en  (hand_step),
    .clr_idx (hand),
    .clr_all (clear_all),
    .bits_o  (bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      vv_q    <= 1'b0;
      vi_q    <= '0;
    end else begin
      vv_q <= found;
      if (found)
        vi_q <= hand;
      unique case (state_q)
        S_IDLE:  if (victim_req) state_q <= S_SCAN;
        S_SCAN:  if (!cur_bit)   state_q <= S_HOLD;
        S_HOLD:  if (install)    state_q <= S_IDLE;
        default:                 state_q <= S_IDLE;
      endcase
    end
  end

  assign victim_valid = vv_q;
  assign victim_idx   = vi_q;

  // R2: a set frame is cleared and the hand moves one step
  p_skip_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SCAN && cur_bit)
    |=> (hand == (($past(hand) == LAST) ? '0 : $past(hand) + 1'b1))
        && !bits[$past(hand)]);

  // R3: reported victim is the frame the hand rests on
  p_victim_at_hand_r3: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> (victim_idx == hand) && (state_q == S_HOLD));

  // R3: valid is a single-cycle pulse
  p_victim_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    victim_valid |=> !victim_valid);

  // R4: install steps the hand and leaves the filled frame clear
  p_install_step_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_HOLD && install)
    |=> (hand == (($past(hand) == LAST) ? '0 : $past(hand) + 1'b1))
        && !bits[$past(hand)] && (state_q == S_IDLE));

  // R6: no movement of the hand while idle
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |=> $stable(hand));
endmodule

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;
  localparam int N     = 16;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             ref_valid;
  logic [IDX_W-1:0] ref_idx;
  logic             clear_all;
  logic             victim_req;
  logic             install;
  logic             victim_valid;
  logic [IDX_W-1:0] victim_idx;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  clock_victim_sel #(.N(N), .IDX_W(IDX_W)) dut (
    .clk          (clk),
    .rst          (rst),
    .ref_valid    (ref_valid),
    .ref_idx      (ref_idx),
    .clear_all    (clear_all),
    .victim_req   (victim_req),
    .install      (install),
    .victim_valid (victim_valid),
    .victim_idx   (victim_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic touch(input int f);
    ref_valid = 1'b1;
    ref_idx   = IDX_W'(f);
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic do_install();
    install = 1'b1;
    @(negedge clk);
    install = 1'b0;
  endtask

  // Request a victim; race_f >= 0 touches that frame in the cycle the
  // second frame of the search is examined.
  task automatic request(input int exp_idx, input int exp_lat, input int race_f,
                         input string req);
    int lat = 0;
    victim_req = 1'b1;
    while (1) begin
      @(negedge clk);
      lat++;
      if (lat == 1) victim_req = 1'b0;
      if (lat == 2 && race_f >= 0) begin
        ref_valid = 1'b1;
        ref_idx   = IDX_W'(race_f);
      end
      if (lat == 3) ref_valid = 1'b0;
      if (victim_valid || lat > 60) break;
    end
    ref_valid = 1'b0;
    check(victim_valid == 1'b1, {req, " valid"}, victim_valid, 1);
    check(victim_idx == IDX_W'(exp_idx), {req, " index"}, victim_idx, exp_idx);
    if (exp_lat >= 0)
      check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    @(negedge clk);
    check(victim_valid == 1'b0, "R3 single pulse", victim_valid, 0);
  endtask

  task automatic t_reset();
    check(victim_valid == 1'b0, "R1 valid low after reset", victim_valid, 0);
    request(0, 2, -1, "R1 first victim");
    do_install();
  endtask

  task automatic t_skip();
    touch(1);
    touch(2);
    request(3, 4, -1, "R2 R7 skip referenced");
    do_install();
  endtask

  task automatic t_ignore();
    do_install();                       // idle: no effect
    request(4, 2, -1, "R6 install ignored in idle");
    victim_req = 1'b1;
    @(negedge clk);
    victim_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(victim_valid == 1'b0, "R6 request ignored while held", victim_valid, 0);
      @(negedge clk);
    end
    do_install();
  endtask

  task automatic t_clear_all();
    touch(5);
    touch(6);
    clear_all = 1'b1;
    @(negedge clk);
    clear_all = 1'b0;
    request(5, 2, -1, "R8 clear_all");
    do_install();
    clear_all = 1'b1;
    touch(6);
    clear_all = 1'b0;
    request(7, 3, -1, "R8 access beats clear_all");
    do_install();
  endtask

  task automatic t_wrap();
    for (int f = 8; f < 16; f++) touch(f);
    request(0, 10, -1, "R10 wrap to frame 0");
    do_install();
  endtask

  task automatic t_sweep();
    for (int f = 0; f < 16; f++) touch(f);
    request(1, 18, -1, "R5 full sweep");
    touch(1);                           // referenced while held
    do_install();
    for (int f = 2; f < 16; f++) touch(f);
    touch(0);
    request(1, 17, -1, "R4 install clears victim bit");
    do_install();
  endtask

  task automatic t_race();
    touch(2);
    touch(3);
    request(4, -1, 3, "R9 race search");
    do_install();
    for (int f = 0; f < 16; f++) if (f != 3) touch(f);
    request(3, 16, -1, "R9 colliding reference lost");
    do_install();
  endtask

  initial begin
    rst = 1'b1; ref_valid = 1'b0; ref_idx = '0; clear_all = 1'b0;
    victim_req = 1'b0; install = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_skip();
    t_ignore();
    t_clear_all();
    t_wrap();
    t_sweep();
    t_race();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule